// File: doc/BRIEF.md
# I2C slave address-match receiver

This block is the receiving front end of an I2C target. It brings the raw SCL and SDA lines through synchronizers and finds START, repeated START and STOP conditions on them. After a START it collects the bits of each byte and checks the address byte against an address register that the host writes. The address can be 7-bit, or 10-bit sent as two address bytes. For each byte it then decides whether to pull SDA low in the acknowledge slot. A byte that is accepted is moved into a receive buffer that the host reads. Each byte addressed to this target raises an interrupt flag.

In 10-bit mode the address register holds only one byte at a time, so the host reloads it between the two address bytes. After each matching address byte the block raises an update request and holds SCL low. It keeps SCL low until the host writes the address register. The host side has five controls:
- an address write;
- a buffer read strobe, which empties the buffer;
- a clear for the interrupt flag;
- a clear for the overflow flag;
- an enable.

Top module: `i2c_addr_rx`

## Requirements
- R1: After reset the buffer-full, overflow, interrupt, update-request and R/W status outputs are 0, and the block drives neither SCL nor SDA.
- R2: While `en` is low, bus traffic is ignored. No acknowledge is driven and the interrupt flag is not set.
- R3: In 7-bit mode, bits [7:1] of the received address byte are compared with bits [7:1] of the address register. Bit 0 of that byte is the R/W bit, where 0 means write. On a match with buffer-full and overflow both 0, four things happen:
  - the address byte is copied to `rx_data`;
  - `buf_full` is set;
  - SDA is pulled low during the 9th SCL clock;
  - `rw_status` takes bit 0 of the address byte.
- R4: A non-matching address byte gets no acknowledge and no interrupt. Later bytes are also ignored until the next START.
- R5: The interrupt flag is set about 3 clock cycles after the falling SCL edge that ends the 9th clock of every byte addressed to this target. This holds whether or not the byte was acknowledged. The flag stays set until `clr_irq` is pulsed.
- R6: A byte that completes while `buf_full` or `ovf` is set gets no acknowledge and leaves `rx_data` unchanged. The interrupt flag is still set. If `buf_full` was set, `ovf` is also set.
- R7: A `rd_en` pulse clears `buf_full`. A `clr_ovf` pulse clears `ovf`, and nothing else clears it.
- R8: In 10-bit mode, a first byte with bits [7:3] = 11110, bits [7:1] equal to address register bits [7:1], and bit 0 = 0 is acknowledged and buffered. After the 9th clock, `upd_req` rises and SCL is held low. Both stay that way until the host writes the address register. A first byte with bit 0 = 1 does not match.
- R9: In 10-bit mode, the second address byte is compared with all 8 bits of the address register. A match behaves as in R8: acknowledge, update request and stretch. After that, data bytes are accepted. A mismatch gets no acknowledge and no stretch, and the data bytes that follow are ignored.
- R10: A STOP returns the block to idle. Bytes clocked after a STOP and without a new START are not acknowledged and raise no interrupt.
- R11: A repeated START during a transfer restarts the address phase. The next byte is treated as an address byte.
- R12: Data bytes received after a matching write address replace `rx_data` and set `buf_full`, provided the buffer was read before they arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Receiver enable |
| ten_bit | input | 1 | 1 selects 10-bit addressing, 0 selects 7-bit addressing |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge) |
| adr_wr | input | 1 | Address register write strobe, also clears `upd_req` |
| adr_wdata | input | 8 | Address register write value |
| rd_en | input | 1 | Buffer read strobe, clears `buf_full` |
| clr_irq | input | 1 | Clears the interrupt flag |
| clr_ovf | input | 1 | Clears the overflow flag |
| rx_data | output | 8 | Receive buffer contents |
| buf_full | output | 1 | Receive buffer holds an unread byte |
| ovf | output | 1 | Overflow flag |
| irq | output | 1 | Interrupt flag |
| upd_req | output | 1 | 10-bit address update request |
| rw_status | output | 1 | R/W bit of the last matching address byte |

## Verification
Every bus-side result lags the SCL edge that causes it by three clock cycles: two synchronizer stages and one state register.
- The acknowledge starts three cycles after the 8th falling edge.
- The interrupt, update request and stretch appear three cycles after the 9th falling edge.

The bench's bus model holds each SCL phase for eight cycles, so it samples SDA in the middle of the 9th high phase, when the acknowledge has long settled. It checks the flags and `rx_data` a full phase after the 9th falling edge. Host strobes act on the next clock edge, and the bench waits several cycles after each strobe before it looks at the result.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned CNT_W  = $clog2(BYTE_W + 2);
    localparam int unsigned PFX_W  = 5;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_ACK  = CNT_W'(BYTE_W + 1);
    localparam logic [PFX_W-1:0] TEN_PREFIX = 5'b11110;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR_HI,
        ST_ADDR_LO,
        ST_DATA,
        ST_SKIP
    } rx_state_e;

    typedef struct packed {
        rx_state_e          st;
        logic [CNT_W-1:0]   cnt;
        logic [BYTE_W-1:0]  shreg;
        logic [BYTE_W-1:0]  rxbuf;
        logic [BYTE_W-1:0]  adr;
        logic               full;
        logic               ovf;
        logic               irq;
        logic               upd;
        logic               ack;
        logic               mine;
        logic               upd_pend;
        logic               rw;
    } core_regs_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int unsigned LINES  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] cur,
    output logic [LINES-1:0] prev
);
    localparam int unsigned DEPTH = STAGES + 1;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [DEPTH-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[DEPTH-2:0], raw[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= chain_d;
        end

        assign cur[g]  = chain_q[STAGES-1];
        assign prev[g] = chain_q[STAGES];
    end
endmodule

// File: rtl/i2c_rx_core.sv
module i2c_rx_core
    import i2c_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              ten_bit,
    input  logic              scl_s,
    input  logic              scl_p,
    input  logic              sda_s,
    input  logic              sda_p,
    input  logic              adr_wr,
    input  logic [BYTE_W-1:0] adr_wdata,
    input  logic              rd_en,
    input  logic              clr_irq,
    input  logic              clr_ovf,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic [BYTE_W-1:0] rx_data,
    output logic              buf_full,
    output logic              ovf,
    output logic              irq,
    output logic              upd_req,
    output logic              rw_status
);
    core_regs_t d, q;
    logic start_c, stop_c, rise_c, fall_c, hi_hit, take;

    assign start_c = scl_s && scl_p && sda_p && !sda_s;
    assign stop_c  = scl_s && scl_p && !sda_p && sda_s;
    assign rise_c  = scl_s && !scl_p;
    assign fall_c  = !scl_s && scl_p;

    assign hi_hit = ten_bit
        ? ((q.shreg[BYTE_W-1:BYTE_W-PFX_W] == TEN_PREFIX) &&
           (q.shreg[BYTE_W-1:1] == q.adr[BYTE_W-1:1]) && !q.shreg[0])
        : (q.shreg[BYTE_W-1:1] == q.adr[BYTE_W-1:1]);

    always_comb begin
        d    = q;
        take = 1'b0;
        if (adr_wr) begin
            d.adr = adr_wdata;
            d.upd = 1'b0;
        end
        if (rd_en)   d.full = 1'b0;
        if (clr_irq) d.irq  = 1'b0;
        if (clr_ovf) d.ovf  = 1'b0;

        if (!en) begin
            d.st = ST_IDLE; d.cnt = '0; d.ack = 1'b0;
            d.mine = 1'b0; d.upd_pend = 1'b0; d.upd = 1'b0;
        end else if (start_c) begin
            d.st = ST_ADDR_HI; d.cnt = '0; d.ack = 1'b0;
            d.mine = 1'b0; d.upd_pend = 1'b0;
        end else if (stop_c) begin
            d.st = ST_IDLE; d.cnt = '0; d.ack = 1'b0;
            d.mine = 1'b0; d.upd_pend = 1'b0;
        end else if (q.st != ST_IDLE) begin
            if (rise_c) begin
                if (q.cnt < CNT_LAST) begin
                    d.shreg = {q.shreg[BYTE_W-2:0], sda_s};
                    d.cnt   = q.cnt + 1'b1;
                end else if (q.cnt == CNT_LAST) begin
                    d.cnt = CNT_ACK;
                end
            end
            if (fall_c && q.cnt == CNT_LAST) begin
                unique case (q.st)
                    ST_ADDR_HI: begin
                        if (hi_hit) begin
                            take       = 1'b1;
                            d.rw       = q.shreg[0];
                            d.upd_pend = ten_bit;
                            d.st = ten_bit ? ST_ADDR_LO
                                           : (q.shreg[0] ? ST_SKIP : ST_DATA);
                        end else begin
                            d.st = ST_SKIP;
                        end
                    end
                    ST_ADDR_LO: begin
                        if (q.shreg == q.adr) begin
                            take       = 1'b1;
                            d.upd_pend = 1'b1;
                            d.st       = ST_DATA;
                        end else begin
                            d.st = ST_SKIP;
                        end
                    end
                    ST_DATA: take = 1'b1;
                    default: ;
                endcase
                if (take) begin
                    d.mine = 1'b1;
                    if (!q.full && !q.ovf) begin
                        d.rxbuf = q.shreg;
                        d.full  = 1'b1;
                        d.ack   = 1'b1;
                    end else if (q.full) begin
                        d.ovf = 1'b1;
                    end
                end
            end else if (fall_c && q.cnt == CNT_ACK) begin
                d.ack      = 1'b0;
                d.cnt      = '0;
                d.mine     = 1'b0;
                d.upd_pend = 1'b0;
                if (q.mine)     d.irq = 1'b1;
                if (q.upd_pend) d.upd = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, default: '0};
        else        q <= d;
    end

    assign scl_oe    = q.upd;
    assign sda_oe    = q.ack;
    assign rx_data   = q.rxbuf;
    assign buf_full  = q.full;
    assign ovf       = q.ovf;
    assign irq       = q.irq;
    assign upd_req   = q.upd;
    assign rw_status = q.rw;

    p_ack_needs_room_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.ack) |-> ($past(!q.full) && $past(!q.ovf)));

    p_ovf_needs_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.ovf) |-> $past(q.full));

    p_buf_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(q.full) |-> $stable(q.rxbuf));

    p_upd_with_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.upd) |-> q.irq);

    p_idle_no_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE) |-> !q.ack);

    p_ack_after_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.ack) |-> q.full);
endmodule

// File: rtl/i2c_addr_rx.sv
module i2c_addr_rx
    import i2c_rx_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              ten_bit,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic              adr_wr,
    input  logic [BYTE_W-1:0] adr_wdata,
    input  logic              rd_en,
    input  logic              clr_irq,
    input  logic              clr_ovf,
    output logic [BYTE_W-1:0] rx_data,
    output logic              buf_full,
    output logic              ovf,
    output logic              irq,
    output logic              upd_req,
    output logic              rw_status
);
    logic [1:0] line_cur, line_prev;

    i2c_line_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   ({sda_i, scl_i}),
        .cur   (line_cur),
        .prev  (line_prev)
    );

    i2c_rx_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .ten_bit   (ten_bit),
        .scl_s     (line_cur[0]),
        .scl_p     (line_prev[0]),
        .sda_s     (line_cur[1]),
        .sda_p     (line_prev[1]),
        .adr_wr    (adr_wr),
        .adr_wdata (adr_wdata),
        .rd_en     (rd_en),
        .clr_irq   (clr_irq),
        .clr_ovf   (clr_ovf),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe),
        .rx_data   (rx_data),
        .buf_full  (buf_full),
        .ovf       (ovf),
        .irq       (irq),
        .upd_req   (upd_req),
        .rw_status (rw_status)
    );
endmodule

// File: tb/tb_i2c_addr_rx.sv
`timescale 1ns/1ps
module tb_i2c_addr_rx;
    localparam int Q = 8;
    localparam int NVEC = 6;
    // vector: [25:18] address reg, [17:10] address byte, [9:2] data byte, [1] addr ack, [0] data ack
    localparam logic [25:0] VECS [NVEC] = '{
        {8'h50, 8'h50, 8'hA5, 1'b1, 1'b1},
        {8'h50, 8'h52, 8'h3C, 1'b0, 1'b0},
        {8'hFE, 8'hFE, 8'h00, 1'b1, 1'b1},
        {8'h02, 8'h02, 8'hFF, 1'b1, 1'b1},
        {8'h50, 8'h51, 8'h66, 1'b1, 1'b0},
        {8'hA0, 8'h20, 8'h5A, 1'b0, 1'b0}
    };

    logic clk = 1'b0, rst_n = 1'b0, en = 1'b1, ten_bit = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic adr_wr = 1'b0, rd_en = 1'b0, clr_irq = 1'b0, clr_ovf = 1'b0;
    logic [7:0] adr_wdata = 8'h00;
    logic scl_oe, sda_oe, buf_full, ovf, irq, upd_req, rw_status;
    logic [7:0] rx_data;
    wire scl_bus = scl_m & ~scl_oe;
    wire sda_bus = sda_m & ~sda_oe;
    int checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    i2c_addr_rx dut (
        .clk(clk), .rst_n(rst_n), .en(en), .ten_bit(ten_bit),
        .scl_i(scl_bus), .sda_i(sda_bus), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .adr_wr(adr_wr), .adr_wdata(adr_wdata), .rd_en(rd_en),
        .clr_irq(clr_irq), .clr_ovf(clr_ovf), .rx_data(rx_data),
        .buf_full(buf_full), .ovf(ovf), .irq(irq), .upd_req(upd_req),
        .rw_status(rw_status)
    );

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic scl_up;
        scl_m = 1'b1;
        while (!scl_bus) cyc(1);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; cyc(Q); scl_up(); cyc(Q);
        sda_m = 1'b0; cyc(Q);
        scl_m = 1'b0; cyc(Q);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; cyc(Q); scl_up(); cyc(Q);
        sda_m = 1'b1; cyc(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; cyc(Q);
            scl_up(); cyc(Q);
            scl_m = 1'b0; cyc(Q);
        end
        sda_m = 1'b1; cyc(Q);
        scl_up(); cyc(Q / 2);
        acked = ~sda_bus;
        cyc(Q / 2);
        scl_m = 1'b0; cyc(Q);
    endtask

    task automatic host_adr(input logic [7:0] v);
        adr_wdata = v; adr_wr = 1'b1; cyc(1); adr_wr = 1'b0; cyc(3);
    endtask
    task automatic host_rd;
        rd_en = 1'b1; cyc(1); rd_en = 1'b0; cyc(3);
    endtask
    task automatic host_clr_irq;
        clr_irq = 1'b1; cyc(1); clr_irq = 1'b0; cyc(3);
    endtask
    task automatic host_clr_ovf;
        clr_ovf = 1'b1; cyc(1); clr_ovf = 1'b0; cyc(3);
    endtask

    task automatic summary;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic a, dk;
        logic [7:0] exp_rx;
        logic [25:0] v;
        exp_rx = 8'h00;
        cyc(5);
        // R1 reset state
        check("R1 buf_full", buf_full, 0);
        check("R1 ovf", ovf, 0);
        check("R1 irq", irq, 0);
        check("R1 upd_req", upd_req, 0);
        check("R1 rw_status", rw_status, 0);
        check("R1 bus drive", {scl_oe, sda_oe}, 0);
        rst_n = 1'b1; cyc(5);

        // table walk: R3 R4 R12
        for (int i = 0; i < NVEC; i++) begin
            v = VECS[i];
            host_adr(v[25:18]);
            bus_start();
            send_byte(v[17:10], a);
            check(v[1] ? "R3 address ack" : "R4 address nack", a, v[1]);
            check(v[1] ? "R5 irq on address" : "R4 no irq", irq, v[1]);
            if (v[1]) begin
                exp_rx = v[17:10];
                check("R3 rx_data address", rx_data, exp_rx);
                check("R3 buf_full", buf_full, 1);
                check("R3 rw_status", rw_status, v[10]);
                host_rd(); host_clr_irq();
            end
            send_byte(v[9:2], dk);
            check(v[0] ? "R12 data ack" : "R4 data ignored", dk, v[0]);
            check("R12 data irq", irq, v[0]);
            if (v[0]) exp_rx = v[9:2];
            check("R12 rx_data", rx_data, exp_rx);
            host_rd(); host_clr_irq();
            bus_stop();
        end

        // R2 disabled
        en = 1'b0;
        host_adr(8'h50);
        bus_start();
        send_byte(8'h50, a);
        check("R2 no ack when disabled", a, 0);
        check("R2 no irq when disabled", irq, 0);
        bus_stop();
        en = 1'b1; cyc(Q);

        // R6 / R7 / R5 overflow sequence
        bus_start();
        send_byte(8'h50, a);
        check("R3 ack", a, 1);
        host_clr_irq();
        send_byte(8'h11, a);
        check("R6 no ack when full", a, 0);
        check("R6 irq still set", irq, 1);
        check("R6 ovf set", ovf, 1);
        check("R6 rx unchanged", rx_data, 8'h50);
        cyc(20);
        check("R5 irq held", irq, 1);
        host_rd();
        check("R7 read clears full", buf_full, 0);
        check("R7 ovf sticky", ovf, 1);
        host_clr_irq();
        check("R5 irq cleared", irq, 0);
        send_byte(8'h22, a);
        check("R6 no ack when ovf", a, 0);
        check("R6 irq with ovf", irq, 1);
        check("R6 rx unchanged ovf", rx_data, 8'h50);
        check("R6 no transfer", buf_full, 0);
        host_clr_ovf();
        check("R7 clr_ovf", ovf, 0);
        host_clr_irq();
        send_byte(8'h33, a);
        check("R12 ack after clear", a, 1);
        check("R12 rx new", rx_data, 8'h33);
        host_rd(); host_clr_irq();
        bus_stop();

        // R10 bytes after STOP without START
        scl_m = 1'b0; cyc(Q);
        send_byte(8'h50, a);
        check("R10 no ack after stop", a, 0);
        check("R10 no irq after stop", irq, 0);
        bus_stop();

        // R11 repeated START
        bus_start();
        send_byte(8'h52, a);
        check("R11 first nack", a, 0);
        bus_start();
        send_byte(8'h50, a);
        check("R11 ack after restart", a, 1);
        host_rd(); host_clr_irq();
        bus_stop();

        // R8 R9 ten-bit match
        ten_bit = 1'b1;
        host_adr(8'hF2);
        bus_start();
        send_byte(8'hF2, a);
        check("R8 hi ack", a, 1);
        check("R8 upd_req", upd_req, 1);
        check("R8 scl held", scl_oe, 1);
        check("R8 rx hi", rx_data, 8'hF2);
        check("R8 irq", irq, 1);
        host_rd(); host_clr_irq();
        cyc(20);
        check("R8 stretch held", scl_oe, 1);
        host_adr(8'h34);
        check("R8 write releases", {upd_req, scl_oe}, 0);
        send_byte(8'h34, a);
        check("R9 lo ack", a, 1);
        check("R9 upd_req", upd_req, 1);
        check("R9 rx lo", rx_data, 8'h34);
        host_rd(); host_clr_irq();
        host_adr(8'hF2);
        check("R9 released", scl_oe, 0);
        send_byte(8'h99, a);
        check("R9 data ack", a, 1);
        check("R9 data rx", rx_data, 8'h99);
        check("R9 no upd on data", upd_req, 0);
        host_rd(); host_clr_irq();
        bus_stop();

        // R9 ten-bit low byte mismatch
        bus_start();
        send_byte(8'hF2, a);
        check("R8 hi ack 2", a, 1);
        host_rd(); host_clr_irq();
        host_adr(8'h35);
        send_byte(8'h34, a);
        check("R9 lo mismatch nack", a, 0);
        check("R9 no stretch", {upd_req, scl_oe}, 0);
        send_byte(8'h77, a);
        check("R9 data ignored", a, 0);
        check("R9 no irq", irq, 0);
        bus_stop();

        // R8 first byte with read bit
        host_adr(8'hF2);
        bus_start();
        send_byte(8'hF3, a);
        check("R8 read bit no match", a, 0);
        check("R8 no upd", upd_req, 0);
        bus_stop();
        ten_bit = 1'b0;

        summary();
        $finish;
    end
endmodule